// File: doc/BRIEF.md
# Register-Driven Serial Flash Write Engine

This block sends write-only commands and payload bytes to a serial flash over a single-line SPI link. Software writes a 32-bit payload word, a 4-bit size code that selects one, two or four bytes, and then a control word that carries the start bits. The engine asserts chip select, waits a programmable setup time, and shifts the selected bytes out. It then waits a programmable hold time and either keeps chip select low or releases it for a programmable idle gap.

The option to keep chip select low lets software chain several separately started transfers into one flash command. A typical chain is an opcode, then an address, then a data burst. Clock polarity and transmit phase are set in a configuration word. The serial clock is the system clock divided by an even ratio. A status bit tells software when the engine may be started again.

Top module: `spiw_engine`

## Requirements
- R1: Size code 4'h8 sends 8 bits, 4'hC sends 16 bits and 4'hF sends 32 bits. A start request carrying any other code is ignored: chip select, the serial clock and the status bit do not change.
- R2: Payload byte 0 (bits 7:0) goes out first, then bytes 1, 2 and 3. Bits within each byte go out MSB first.
- R3: A transfer starts only when the control word (address 4) is written with bit 0 and bit 1 both set. Chip select falls in the cycle the write is taken. Bits 0 and 1 of the control word read back as 0.
- R4: If control bit 8 is set in the starting write, chip select stays low after the transfer, and bit 8 reads back as 1. A transfer started while chip select is already low skips the setup delay: its first clock edge comes HALF+1 cycles after the start write. The hold delay still runs before the status bit returns to 1.
- R5: Status (address 5) bit 0 reads 1 when the engine is idle. It reads 0 from the cycle after an accepted start until the transfer, including its idle gap, completes.
- R6: A start request made while the engine is busy is ignored. No extra bits are sent, and the running transfer finishes on its own schedule.
- R7: Configuration (address 0) bit 0 sets the serial clock idle level. Bit 1 selects the transmit phase. With phase 0, data is stable across each leading clock edge. With phase 1, data changes on leading edges and is stable across each trailing edge. Bit 2 is a receive-phase bit that is stored and read back only.
- R8: Configuration bits 15:8 hold HALF. Successive serial clock edges are HALF+1 system cycles apart, so one period P is 2*(HALF+1) cycles.
- R9: Timing word (address 1) bits 2:0 hold the setup code S. From chip select falling to the first clock edge takes (S+1)*P + HALF+1 cycles.
- R10: Timing bits 6:4 hold the hold code H. From the last clock edge to chip select rising takes (H+1)*P cycles.
- R11: Timing bits 10:8 hold the gap code G. From chip select rising to status bit 0 reading 1 takes (G+1)*P cycles.
- R12: After reset, chip select is high, the serial clock and data line are low, status reads 1 and the configuration word reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 3 | Register write word address |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_addr | input | 3 | Register read word address |
| reg_rd_data | output | 32 | Register read data (combinational) |
| spi_sck | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data out |

## Verification
A miscounted edge counter shows up within one transfer as a wrong number of captured bits or a late chip-select release. A wrong byte order or shift phase shows up as a wrong captured word, or as data moving across the sampling edge. A timer loaded with the wrong span skews the measured setup, hold or gap intervals by whole half-periods. A stale keep flag releases or holds chip select wrongly at the first transfer end. A busy engine that accepts a second start produces extra clock edges before the status bit returns.

// File: rtl/spiw_pkg.sv
package spiw_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LEAD,
      ST_SHIFT,
      ST_TRAIL,
      ST_GAP
   } spiw_state_e;

   localparam logic [2:0] A_CFG    = 3'd0;
   localparam logic [2:0] A_TIMING = 3'd1;
   localparam logic [2:0] A_WDATA  = 3'd2;
   localparam logic [2:0] A_SIZE   = 3'd3;
   localparam logic [2:0] A_CTRL   = 3'd4;
   localparam logic [2:0] A_STATUS = 3'd5;

   localparam int CTRL_EN_BIT   = 0;
   localparam int CTRL_WE_BIT   = 1;
   localparam int CTRL_KEEP_BIT = 8;

   // Number of bits for a size code; 0 marks an illegal code.
   function automatic logic [6:0] size_bits(input logic [3:0] code);
      case (code)
         4'h8:    size_bits = 7'd8;
         4'hC:    size_bits = 7'd16;
         4'hF:    size_bits = 7'd32;
         default: size_bits = 7'd0;
      endcase
   endfunction

endpackage

// File: rtl/spiw_regs.sv
module spiw_regs
   import spiw_pkg::*;
#(
   parameter int ADDR_W = 3,
   parameter int DATA_W = 32,
   parameter int HDIV_W = 8,
   parameter int DLY_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              done,
   output logic              cpol,
   output logic              cpha_tx,
   output logic [HDIV_W-1:0] hdiv,
   output logic [DLY_W-1:0]  lead_dl,
   output logic [DLY_W-1:0]  trail_dl,
   output logic [DLY_W-1:0]  gap_dl,
   output logic [DATA_W-1:0] wdata,
   output logic [3:0]        size_code,
   output logic              start_req,
   output logic              keep_req
);
   localparam int LEAD_LSB  = 0;
   localparam int TRAIL_LSB = 4;
   localparam int GAP_LSB   = 8;
   localparam int HDIV_LSB  = 8;

   logic cpha_rx;
   logic keep_r;

   wire wr_cfg  = wr_en && (wr_addr == ADDR_W'(A_CFG));
   wire wr_tim  = wr_en && (wr_addr == ADDR_W'(A_TIMING));
   wire wr_dat  = wr_en && (wr_addr == ADDR_W'(A_WDATA));
   wire wr_siz  = wr_en && (wr_addr == ADDR_W'(A_SIZE));
   wire wr_ctl  = wr_en && (wr_addr == ADDR_W'(A_CTRL));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cpol      <= 1'b0;
         cpha_tx   <= 1'b0;
         cpha_rx   <= 1'b0;
         hdiv      <= '0;
         lead_dl   <= '0;
         trail_dl  <= '0;
         gap_dl    <= '0;
         wdata     <= '0;
         size_code <= '0;
         keep_r    <= 1'b0;
      end else begin
         if (wr_cfg) begin
            cpol    <= wr_data[0];
            cpha_tx <= wr_data[1];
            cpha_rx <= wr_data[2];
            hdiv    <= wr_data[HDIV_LSB +: HDIV_W];
         end
         if (wr_tim) begin
            lead_dl  <= wr_data[LEAD_LSB  +: DLY_W];
            trail_dl <= wr_data[TRAIL_LSB +: DLY_W];
            gap_dl   <= wr_data[GAP_LSB   +: DLY_W];
         end
         if (wr_dat) wdata     <= wr_data;
         if (wr_siz) size_code <= wr_data[3:0];
         if (wr_ctl) keep_r    <= wr_data[CTRL_KEEP_BIT];
      end
   end

   assign start_req = wr_ctl && wr_data[CTRL_EN_BIT] && wr_data[CTRL_WE_BIT];
   assign keep_req  = wr_data[CTRL_KEEP_BIT];

   always_comb begin
      rd_data = '0;
      case (rd_addr)
         ADDR_W'(A_CFG): begin
            rd_data[0] = cpol;
            rd_data[1] = cpha_tx;
            rd_data[2] = cpha_rx;
            rd_data[HDIV_LSB +: HDIV_W] = hdiv;
         end
         ADDR_W'(A_TIMING): begin
            rd_data[LEAD_LSB  +: DLY_W] = lead_dl;
            rd_data[TRAIL_LSB +: DLY_W] = trail_dl;
            rd_data[GAP_LSB   +: DLY_W] = gap_dl;
         end
         ADDR_W'(A_WDATA):  rd_data = wdata;
         ADDR_W'(A_SIZE):   rd_data[3:0] = size_code;
         ADDR_W'(A_CTRL):   rd_data[CTRL_KEEP_BIT] = keep_r;
         ADDR_W'(A_STATUS): rd_data[0] = done;
         default:           rd_data = '0;
      endcase
   end

   logic unused_wr_bits;
   assign unused_wr_bits = ^{wr_data[DATA_W-1:HDIV_LSB+HDIV_W], wr_data[7:3]};

endmodule

// File: rtl/spiw_timer.sv
module spiw_timer #(
   parameter int CNT_W = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (load)       cnt <= load_val;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign expired = (cnt == '0);

endmodule

// File: rtl/spiw_shift.sv
module spiw_shift #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] load_data,
   input  logic              shift,
   output logic              mosi
);
   logic [DATA_W-1:0] sreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sreg <= '0;
      else if (load)   sreg <= load_data;
      else if (shift)  sreg <= {sreg[DATA_W-2:0], 1'b0};
   end

   assign mosi = sreg[DATA_W-1];

endmodule

// File: rtl/spiw_engine.sv
module spiw_engine
   import spiw_pkg::*;
#(
   parameter int ADDR_W = 3,
   parameter int DATA_W = 32,
   parameter int HDIV_W = 8,
   parameter int DLY_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr_en,
   input  logic [ADDR_W-1:0] reg_wr_addr,
   input  logic [DATA_W-1:0] reg_wr_data,
   input  logic [ADDR_W-1:0] reg_rd_addr,
   output logic [DATA_W-1:0] reg_rd_data,
   output logic              spi_sck,
   output logic              spi_cs_n,
   output logic              spi_mosi
);
   localparam int NBYTES = DATA_W / 8;
   localparam int CNT_W  = HDIV_W + DLY_W + 3;
   localparam int EC_W   = $clog2(2 * DATA_W);

   if (DATA_W != 32) begin : g_bad_width
      $error("spiw_engine: size codes cover 8/16/32 bits, DATA_W must be 32");
   end
   if (DLY_W < 1 || HDIV_W < 1) begin : g_bad_timing
      $error("spiw_engine: delay and divider fields need at least one bit");
   end

   logic              cfg_cpol, cfg_cpha;
   logic [HDIV_W-1:0] hdiv;
   logic [DLY_W-1:0]  lead_dl, trail_dl, gap_dl;
   logic [DATA_W-1:0] wdata, swapped;
   logic [3:0]        size_code;
   logic              start_req, keep_req;
   logic              idle;

   spiw_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .HDIV_W(HDIV_W), .DLY_W(DLY_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en(reg_wr_en), .wr_addr(reg_wr_addr), .wr_data(reg_wr_data),
      .rd_addr(reg_rd_addr), .rd_data(reg_rd_data), .done(idle),
      .cpol(cfg_cpol), .cpha_tx(cfg_cpha), .hdiv(hdiv),
      .lead_dl(lead_dl), .trail_dl(trail_dl), .gap_dl(gap_dl),
      .wdata(wdata), .size_code(size_code),
      .start_req(start_req), .keep_req(keep_req)
   );

   // Byte 0 lands in the top byte so it leaves first, MSB first.
   for (genvar b = 0; b < NBYTES; b++) begin : g_swap
      assign swapped[DATA_W-1-8*b -: 8] = wdata[8*b +: 8];
   end

   function automatic logic [CNT_W-1:0] span_m1(input logic [HDIV_W-1:0] h,
                                                input logic [DLY_W-1:0]  d);
      logic [CNT_W-1:0] per;
      per     = (CNT_W'(h) + 1'b1) << 1;
      span_m1 = per * (CNT_W'(d) + 1'b1) - 1'b1;
   endfunction

   spiw_state_e    st;
   logic [EC_W-1:0] ec, lim_q;
   logic           keep_q, cpha_q;
   logic           sck_q, cs_n_q;
   logic           exp_t, t_load, shift_en, go;
   logic [CNT_W-1:0] t_val;

   wire [6:0]      req_bits  = size_bits(size_code);
   wire [EC_W:0]   req_lim   = {req_bits[EC_W-1:0], 1'b0} - 1'b1;
   wire [CNT_W-1:0] half     = CNT_W'(hdiv);
   wire            edge_now  = (st == ST_SHIFT) && exp_t;
   wire            last_edge = (ec == lim_q);
   wire            leading   = ~ec[0];

   assign idle = (st == ST_IDLE);
   assign go   = start_req && idle && (req_bits != '0);

   always_comb begin
      t_load = 1'b0;
      t_val  = half;
      if (go) begin
         t_load = 1'b1;
         t_val  = cs_n_q ? span_m1(hdiv, lead_dl) : half;
      end else if (st == ST_LEAD && exp_t) begin
         t_load = 1'b1;
      end else if (edge_now) begin
         t_load = 1'b1;
         t_val  = last_edge ? span_m1(hdiv, trail_dl) : half;
      end else if (st == ST_TRAIL && exp_t && !keep_q) begin
         t_load = 1'b1;
         t_val  = span_m1(hdiv, gap_dl);
      end
   end

   assign shift_en = edge_now && (cpha_q ? (leading && ec != '0) : !leading);

   spiw_timer #(.CNT_W(CNT_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .expired(exp_t)
   );

   spiw_shift #(.DATA_W(DATA_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .load(go), .load_data(swapped),
      .shift(shift_en), .mosi(spi_mosi)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         ec     <= '0;
         lim_q  <= '0;
         keep_q <= 1'b0;
         cpha_q <= 1'b0;
         sck_q  <= 1'b0;
         cs_n_q <= 1'b1;
      end else begin
         case (st)
            ST_IDLE: begin
               sck_q <= cfg_cpol;
               if (go) begin
                  keep_q <= keep_req;
                  cpha_q <= cfg_cpha;
                  lim_q  <= req_lim[EC_W-1:0];
                  ec     <= '0;
                  cs_n_q <= 1'b0;
                  st     <= cs_n_q ? ST_LEAD : ST_SHIFT;
               end
            end
            ST_LEAD: begin
               sck_q <= cfg_cpol;
               if (exp_t) st <= ST_SHIFT;
            end
            ST_SHIFT: begin
               if (exp_t) begin
                  sck_q <= ~sck_q;
                  ec    <= ec + 1'b1;
                  if (last_edge) st <= ST_TRAIL;
               end
            end
            ST_TRAIL: begin
               if (exp_t) begin
                  if (keep_q) st <= ST_IDLE;
                  else begin
                     cs_n_q <= 1'b1;
                     st     <= ST_GAP;
                  end
               end
            end
            ST_GAP: begin
               if (exp_t) st <= ST_IDLE;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign spi_sck  = sck_q;
   assign spi_cs_n = cs_n_q;

   logic unused_req;
   assign unused_req = ^req_lim[EC_W] ^ ^req_bits[6];

endmodule

// File: rtl/spiw_checker.sv
module spiw_checker #(
   parameter int EC_W = 6
) (
   input logic            clk,
   input logic            rst_n,
   input logic            spi_sck,
   input logic            spi_cs_n,
   input logic            idle,
   input logic            cpol,
   input logic            go,
   input logic            start_req,
   input logic            keep_q,
   input logic [EC_W-1:0] lim_q
);
   // R1: a running transfer always carries a legal edge limit
   a_r1_legal_limit: assert property (@(posedge clk) disable iff (!rst_n)
      !idle |-> (lim_q == EC_W'(15) || lim_q == EC_W'(31) || lim_q == EC_W'(63)));

   // R5: an accepted start makes the engine busy next cycle
   a_r5_busy_after_go: assert property (@(posedge clk) disable iff (!rst_n)
      go |=> !idle);

   // R6: a start during a transfer does not reload the transfer settings
   a_r6_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (start_req && !idle) |=> ($stable(keep_q) && $stable(lim_q)));

   // R4: a kept transfer ends with chip select still low
   a_r4_keep_holds_cs: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(idle) && keep_q) |-> !spi_cs_n);

   // R11: chip select rises while the gap is still running
   a_r11_release_before_done: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(spi_cs_n) |-> !idle);

   // R7: with chip select high the clock only follows the idle level
   a_r7_sck_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
      $changed(spi_sck) |-> (!spi_cs_n || spi_sck == $past(cpol)));

endmodule

bind spiw_engine spiw_checker #(.EC_W(EC_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
   .idle(idle), .cpol(cfg_cpol), .go(go), .start_req(start_req),
   .keep_q(keep_q), .lim_q(lim_q)
);

// File: tb/tb_spiw_engine.sv
`timescale 1ns/1ps
module tb_spiw_engine;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr_en = 1'b0;
   logic [2:0]  reg_wr_addr = '0;
   logic [31:0] reg_wr_data = '0;
   logic [2:0]  reg_rd_addr = '0;
   logic [31:0] reg_rd_data;
   logic        spi_sck, spi_cs_n, spi_mosi;

   spiw_engine dut (
      .clk(clk), .rst_n(rst_n),
      .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
      .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
      .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi)
   );

   always #10 clk = ~clk;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   // bench-side copy of the programmed configuration
   int b_cpol = 0, b_cpha = 0, b_h = 0, b_lead = 0, b_trail = 0, b_gap = 0;

   // monitor state
   logic        prev_sck = 1'b0, prev_cs = 1'b1, prev_mosi = 1'b0;
   logic [31:0] rx = '0;
   int nb = 0, n_edges = 0, n_csrise = 0, hold_bad = 0;
   int t_csfall = 0, t_first = 0, t_last = 0, t_csrise = 0;
   bit first_seen = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (prev_cs && !spi_cs_n) t_csfall = cyc;
         if (!prev_cs && spi_cs_n) begin t_csrise = cyc; n_csrise++; end
         if (spi_sck != prev_sck && !spi_cs_n) begin
            if (!first_seen) begin t_first = cyc; first_seen = 1; end
            t_last = cyc;
            n_edges++;
            if ((spi_sck != b_cpol[0]) == (b_cpha == 0)) begin
               rx = {rx[30:0], spi_mosi};
               nb++;
               if (spi_mosi != prev_mosi) hold_bad++;
            end
         end
      end
      prev_sck  = spi_sck;
      prev_cs   = spi_cs_n;
      prev_mosi = spi_mosi;
   end

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
      @(negedge clk);
      reg_wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      reg_rd_addr = a;
      #1;
      d = reg_rd_data;
   endtask

   function automatic int bits_of(input logic [3:0] c);
      case (c)
         4'h8: return 8;
         4'hC: return 16;
         4'hF: return 32;
         default: return 0;
      endcase
   endfunction

   function automatic logic [31:0] exp_word(input logic [31:0] w, input int n);
      logic [31:0] s;
      s = {w[7:0], w[15:8], w[23:16], w[31:24]};
      return s >> (32 - n);
   endfunction

   function automatic int per();
      return 2 * (b_h + 1);
   endfunction

   task automatic config_link(input int cpol, input int cpha, input int h,
                              input int lead, input int trail, input int gap);
      b_cpol = cpol; b_cpha = cpha; b_h = h;
      b_lead = lead; b_trail = trail; b_gap = gap;
      wr(3'd0, 32'(cpol) | (32'(cpha) << 1) | (32'(h) << 8));
      wr(3'd1, 32'(lead) | (32'(trail) << 4) | (32'(gap) << 8));
      repeat (2) @(negedge clk);
   endtask

   task automatic xfer(input logic [31:0] data, input logic [3:0] code,
                       input bit keep, input bit poke);
      logic [31:0] v;
      int n, t_start, t_done, rises0, guard;
      bit cs_was_low;
      n = bits_of(code);
      wr(3'd2, data);
      wr(3'd3, 32'(code));
      nb = 0; rx = '0; n_edges = 0; hold_bad = 0; first_seen = 0;
      rises0 = n_csrise;
      cs_was_low = !spi_cs_n;
      wr(3'd4, (32'(keep) << 8) | 32'h3);
      t_start = cyc;
      rd(3'd5, v);
      check(v[0] == 1'b0, "R5 busy after start", v[0], 0);
      if (poke) begin
         repeat (4) @(negedge clk);
         wr(3'd2, ~data);
         wr(3'd4, 32'h3);
      end
      guard = 0;
      t_done = 0;
      while (guard < 20000) begin
         @(negedge clk);
         rd(3'd5, v);
         if (v[0]) begin t_done = cyc; break; end
         guard++;
      end
      check(guard < 20000, "R5 done returns", guard, 0);
      check(nb == n, "R1 bit count", nb, n);
      check(rx == exp_word(data, n), "R2 serial word", rx, exp_word(data, n));
      check(hold_bad == 0, "R7 data stable at sampling edge", hold_bad, 0);
      check((t_last - t_first) == (2 * n - 1) * (b_h + 1), "R8 edge spacing",
            t_last - t_first, (2 * n - 1) * (b_h + 1));
      if (cs_was_low) begin
         check((t_first - t_start) == b_h + 1, "R4 chained start skips setup",
               t_first - t_start, b_h + 1);
      end else begin
         check(t_csfall == t_start, "R3 cs falls on start", t_csfall, t_start);
         check((t_first - t_csfall) == (b_lead + 1) * per() + b_h + 1, "R9 setup delay",
               t_first - t_csfall, (b_lead + 1) * per() + b_h + 1);
      end
      if (keep) begin
         check(spi_cs_n == 1'b0 && n_csrise == rises0, "R4 cs kept low", spi_cs_n, 0);
         check((t_done - t_last) == (b_trail + 1) * per(), "R4 hold before done",
               t_done - t_last, (b_trail + 1) * per());
         rd(3'd4, v);
         check(v == 32'h100, "R3 start bits clear, R4 keep reads 1", v, 32'h100);
      end else begin
         check(n_csrise == rises0 + 1, "R4 cs released once", n_csrise - rises0, 1);
         check((t_csrise - t_last) == (b_trail + 1) * per(), "R10 hold delay",
               t_csrise - t_last, (b_trail + 1) * per());
         check((t_done - t_csrise) == (b_gap + 1) * per(), "R11 gap delay",
               t_done - t_csrise, (b_gap + 1) * per());
      end
      check(spi_sck == b_cpol[0], "R7 idle clock level", spi_sck, b_cpol);
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [31:0] v;
      int seed;
      seed = $urandom(32'd2024);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R12 reset state
      check(spi_cs_n == 1'b1, "R12 cs high", spi_cs_n, 1);
      check(spi_sck == 1'b0 && spi_mosi == 1'b0, "R12 sck/mosi low", {spi_sck, spi_mosi}, 0);
      rd(3'd5, v);
      check(v == 32'h1, "R12 status idle", v, 1);
      rd(3'd0, v);
      check(v == 32'h0, "R12 config zero", v, 0);

      // directed sizes and modes
      config_link(0, 0, 0, 0, 0, 0);
      xfer(32'hA5C3_1E81, 4'h8, 0, 0);
      config_link(1, 0, 1, 2, 1, 3);
      xfer(32'h1234_5678, 4'hC, 0, 0);
      config_link(0, 1, 2, 1, 3, 0);
      xfer(32'hDEAD_BEEF, 4'hF, 0, 0);
      config_link(1, 1, 3, 7, 7, 7);
      xfer(32'h8001_7FFE, 4'hF, 0, 0);

      // R7 receive-phase bit stored only
      wr(3'd0, 32'h0000_0104);
      rd(3'd0, v);
      check(v == 32'h0000_0104, "R7 receive phase readback", v, 32'h104);
      config_link(0, 0, 1, 1, 1, 1);

      // R4 chained transfers under one chip select
      xfer(32'h0000_0006, 4'h8, 1, 0);
      xfer(32'h00AB_CD02, 4'hF, 1, 0);
      xfer(32'h0000_55AA, 4'hC, 0, 0);

      // R1 illegal size code ignored
      n_edges = 0;
      wr(3'd3, 32'h9);
      wr(3'd4, 32'h3);
      repeat (20) @(negedge clk);
      rd(3'd5, v);
      check(v[0] == 1'b1 && spi_cs_n == 1'b1 && n_edges == 0, "R1 illegal code ignored",
            {v[0], spi_cs_n, 8'(n_edges)}, 2'b11 << 8);

      // R3 partial start bits do nothing
      wr(3'd3, 32'h8);
      wr(3'd4, 32'h1);
      wr(3'd4, 32'h2);
      repeat (20) @(negedge clk);
      rd(3'd5, v);
      check(v[0] == 1'b1 && spi_cs_n == 1'b1 && n_edges == 0, "R3 single start bit ignored",
            {v[0], spi_cs_n, 8'(n_edges)}, 2'b11 << 8);

      // R6 start while busy ignored
      config_link(0, 0, 3, 2, 1, 1);
      xfer(32'hC0FF_EE11, 4'hF, 0, 1);
      check(n_edges == 64, "R6 no extra edges", n_edges, 64);

      // constrained random transfers
      for (int i = 0; i < 24; i++) begin
         logic [3:0] code;
         int pick;
         pick = int'($urandom % 3);
         code = (pick == 0) ? 4'h8 : (pick == 1) ? 4'hC : 4'hF;
         config_link(int'($urandom % 2), int'($urandom % 2), int'($urandom % 4),
                     int'($urandom % 8), int'($urandom % 8), int'($urandom % 8));
         xfer($urandom, code, 0, 0);
      end
      finish_run();
   end
endmodule